// File: doc/BRIEF.md
# Instruction Trace Exception Controller

This block decides, once per retired instruction, whether a debugger trace exception must be raised. It takes a two-bit trace-mode field from the status register, a strobe that marks the start of an instruction, a strobe that marks its completion, and classification flags describing the completing instruction. Its output is a trace request to the exception sequencer, together with the vector number to use.

The mode field is captured when an instruction starts, so an instruction that rewrites the status register is judged by the mode that was in force when it began. The block follows one instruction at a time. A completion strobe with no matching start is discarded. Once raised, a request stays up until the sequencer acknowledges it.

Top module: `trace_exc_ctrl`

## Requirements
- R1: `mode_bits[1]` is the upper trace bit and `mode_bits[0]` the lower one. The encoding is 2'b00 = off, 2'b01 = trace on change of flow, 2'b10 = trace every instruction, and 2'b11 = reserved, which behaves exactly like off.
- R2: When the captured mode is off or reserved, a completing instruction never raises a request.
- R3: In change-of-flow mode, a request is raised only when the completing instruction has `is_cof` or `is_sr_write` set. An instruction that only advances the program counter (all class flags low) raises none.
- R4: In trace-everything mode, every completing instruction raises a request, whatever its class flags.
- R5: When `is_bkpt` is high, `is_cof` is ignored and `bkpt_sub_cof` decides whether the instruction counts as a change of flow. `is_sr_write` still counts.
- R6: The mode used for an instruction is the value of `mode_bits` in the cycle its `instr_start` is sampled. Changes to `mode_bits` before its `instr_done` have no effect on that decision.
- R7: A request becomes visible on `trace_req` in the cycle after `instr_done` is sampled, and not before.
- R8: `trace_req` stays high until `trace_ack` is sampled high, then goes low in the next cycle. If a new request is raised in the same cycle as the acknowledge, `trace_req` stays high.
- R9: `trace_vector` reads 9 while `trace_req` is high and 0 otherwise.
- R10: An `instr_done` with no instruction in flight (no `instr_start` since the last completion) is ignored, including a second completion after a single start.
- R11: After reset, `trace_req` is low and no instruction is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_bits | input | 2 | Trace-mode field from the status register |
| instr_start | input | 1 | Pulse: an instruction begins |
| instr_done | input | 1 | Pulse: the instruction in flight completes |
| is_cof | input | 1 | Completing instruction changes program flow |
| is_sr_write | input | 1 | Completing instruction can modify the status register |
| is_bkpt | input | 1 | Completing instruction is a breakpoint |
| bkpt_sub_cof | input | 1 | The opcode substituted for the breakpoint changes flow |
| trace_ack | input | 1 | Exception sequencer accepts the request |
| trace_req | output | 1 | Trace exception pending |
| trace_vector | output | VEC_W (8) | Vector number while a request is pending |

## Verification
The hardest situations to reach are those where timing decides the outcome. One is a mode change between start and completion. Another is an acknowledge that lands in the same cycle as a fresh request. The driver reaches the first by presenting one mode with `instr_start` and a different one with `instr_done`, in both directions. It reaches the second by holding a request unacknowledged, then issuing a short instruction whose completion coincides with `trace_ack`. Orphan and duplicate completions are also issued, to show the in-flight tracking discards them.

// File: rtl/trace_pkg.sv
package trace_pkg;

    typedef enum logic [1:0] {
        TM_OFF  = 2'b00,
        TM_FLOW = 2'b01,
        TM_ALL  = 2'b10,
        TM_RSVD = 2'b11
    } trace_mode_e;

    typedef struct packed {
        logic cof;
        logic sr_write;
        logic bkpt;
        logic bkpt_sub_cof;
    } instr_class_t;

    // A breakpoint takes its flow class from the substituted opcode.
    function automatic logic flow_change(instr_class_t c);
        return (c.bkpt ? c.bkpt_sub_cof : c.cof) | c.sr_write;
    endfunction

    function automatic logic trace_wanted(trace_mode_e m, instr_class_t c);
        logic r;
        case (m)
            TM_FLOW: r = flow_change(c);
            TM_ALL:  r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/trc_mode_latch.sv
module trc_mode_latch
    import trace_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  mode_bits,
    input  logic        start,
    input  logic        done,
    output trace_mode_e held_mode,
    output logic        busy,
    output logic        retire
);
    assign retire = done & busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_mode <= TM_OFF;
            busy      <= 1'b0;
        end else begin
            if (start) begin
                held_mode <= trace_mode_e'(mode_bits);
                busy      <= 1'b1;
            end else if (done) begin
                busy      <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/trc_decide.sv
module trc_decide
    import trace_pkg::*;
(
    input  logic         retire,
    input  trace_mode_e  held_mode,
    input  instr_class_t cls,
    output logic         raise
);
    always_comb begin
        raise = retire & trace_wanted(held_mode, cls);
    end
endmodule

// File: rtl/trc_request.sv
module trc_request #(
    parameter int VEC_W        = 8,
    parameter int TRACE_VECTOR = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raise,
    input  logic             ack,
    output logic             req,
    output logic [VEC_W-1:0] vector
);
    localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(TRACE_VECTOR);

    always_ff @(posedge clk) begin
        if (rst)        req <= 1'b0;
        else if (raise) req <= 1'b1;
        else if (ack)   req <= 1'b0;
    end

    assign vector = req ? VEC_VAL : '0;
endmodule

// File: rtl/trace_exc_ctrl.sv
module trace_exc_ctrl
    import trace_pkg::*;
#(
    parameter int VEC_W        = 8,
    parameter int TRACE_VECTOR = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_bits,
    input  logic             instr_start,
    input  logic             instr_done,
    input  logic             is_cof,
    input  logic             is_sr_write,
    input  logic             is_bkpt,
    input  logic             bkpt_sub_cof,
    input  logic             trace_ack,
    output logic             trace_req,
    output logic [VEC_W-1:0] trace_vector
);
    trace_mode_e  held_mode;
    logic         busy;
    logic         retire;
    logic         raise;
    instr_class_t cls;

    assign cls = '{cof: is_cof, sr_write: is_sr_write,
                   bkpt: is_bkpt, bkpt_sub_cof: bkpt_sub_cof};

    trc_mode_latch u_latch (
        .clk(clk), .rst(rst), .mode_bits(mode_bits),
        .start(instr_start), .done(instr_done),
        .held_mode(held_mode), .busy(busy), .retire(retire)
    );

    trc_decide u_decide (
        .retire(retire), .held_mode(held_mode), .cls(cls), .raise(raise)
    );

    trc_request #(.VEC_W(VEC_W), .TRACE_VECTOR(TRACE_VECTOR)) u_req (
        .clk(clk), .rst(rst), .raise(raise), .ack(trace_ack),
        .req(trace_req), .vector(trace_vector)
    );
endmodule

// File: rtl/trace_exc_ctrl_chk.sv
module trace_exc_ctrl_chk #(
    parameter int VEC_W        = 8,
    parameter int TRACE_VECTOR = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             instr_done,
    input logic             trace_ack,
    input logic             trace_req,
    input logic [VEC_W-1:0] trace_vector,
    input logic [1:0]       held_mode,
    input logic             busy
);
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (instr_done && busy && (held_mode == 2'b00 || held_mode == 2'b11) && !trace_req)
        |=> !trace_req);

    p_all_traced_r4: assert property (@(posedge clk) disable iff (rst)
        (instr_done && busy && held_mode == 2'b10) |=> trace_req);

    p_rise_after_done_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(trace_req) |-> $past(instr_done && busy));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (trace_req && !trace_ack) |=> trace_req);

    p_ack_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (trace_req && trace_ack && !(instr_done && busy)) |=> !trace_req);

    p_vector_r9: assert property (@(posedge clk) disable iff (rst)
        trace_req |-> (trace_vector == VEC_W'(TRACE_VECTOR)));

    p_orphan_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !trace_req) |=> !trace_req);
endmodule

bind trace_exc_ctrl trace_exc_ctrl_chk #(.VEC_W(VEC_W), .TRACE_VECTOR(TRACE_VECTOR)) u_chk (
    .clk(clk), .rst(rst), .instr_done(instr_done), .trace_ack(trace_ack),
    .trace_req(trace_req), .trace_vector(trace_vector),
    .held_mode(held_mode), .busy(busy)
);

// File: tb/test_trace_exc_ctrl.sv
module test_trace_exc_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_bits = 2'b00;
    logic       instr_start = 1'b0, instr_done = 1'b0;
    logic       is_cof = 1'b0, is_sr_write = 1'b0, is_bkpt = 1'b0, bkpt_sub_cof = 1'b0;
    logic       trace_ack = 1'b0;
    logic       trace_req;
    logic [7:0] trace_vector;

    int n_cmp = 0, n_bad = 0;

    bit    exp_q[$];
    string tag_q[$];
    bit    armed = 1'b0;
    bit    cur_exp;
    string cur_tag;

    always #4 clk = ~clk;

    trace_exc_ctrl i_trace_exc_ctrl (
        .clk(clk), .rst(rst), .mode_bits(mode_bits),
        .instr_start(instr_start), .instr_done(instr_done),
        .is_cof(is_cof), .is_sr_write(is_sr_write), .is_bkpt(is_bkpt),
        .bkpt_sub_cof(bkpt_sub_cof), .trace_ack(trace_ack),
        .trace_req(trace_req), .trace_vector(trace_vector)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // Monitor: capture the expectation at the completion edge, compare half a cycle later.
    always @(posedge clk) begin
        if (instr_done && exp_q.size() > 0) begin
            cur_exp = exp_q.pop_front();
            cur_tag = tag_q.pop_front();
            armed   = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (armed) begin
            check(trace_req == cur_exp, cur_tag, trace_req, cur_exp);
            check(trace_vector == (cur_exp ? 8'd9 : 8'd0), "R9 vector",
                  trace_vector, cur_exp ? 9 : 0);
            armed = 1'b0;
        end
    end

    task automatic ack_and_check();
        @(negedge clk) trace_ack = 1'b1;
        @(negedge clk) trace_ack = 1'b0;
        check(trace_req == 1'b0, "R8 drop after ack", trace_req, 0);
    endtask

    // cls = {cof, sr_write, bkpt, bkpt_sub_cof}
    task automatic run_instr(input logic [1:0] m_start, input logic [1:0] m_done,
                             input logic [3:0] cls, input bit exp, input string tag,
                             input bit do_ack);
        @(negedge clk);
        mode_bits   = m_start;
        instr_start = 1'b1;
        @(negedge clk);
        instr_start = 1'b0;
        mode_bits   = m_done;
        {is_cof, is_sr_write, is_bkpt, bkpt_sub_cof} = cls;
        instr_done  = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        #1 check(trace_req == 1'b0, "R7 not before edge", trace_req, 0);
        @(negedge clk);
        instr_done = 1'b0;
        {is_cof, is_sr_write, is_bkpt, bkpt_sub_cof} = 4'b0000;
        if (exp && do_ack) ack_and_check();
    endtask

    task automatic orphan_done(input string tag);
        @(negedge clk);
        mode_bits  = 2'b10;
        instr_done = 1'b1;
        exp_q.push_back(1'b0);
        tag_q.push_back(tag);
        @(negedge clk) instr_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(trace_req == 1'b0, "R11 reset req", trace_req, 0);
        check(trace_vector == 8'd0, "R11 reset vector", trace_vector, 0);
        orphan_done("R11 nothing in flight after reset");

        run_instr(2'b00, 2'b00, 4'b1000, 1'b0, "R2 off cof", 1);
        run_instr(2'b00, 2'b00, 4'b0100, 1'b0, "R2 off sr_write", 1);
        run_instr(2'b11, 2'b11, 4'b1100, 1'b0, "R1 reserved acts off", 1);
        run_instr(2'b01, 2'b01, 4'b0000, 1'b0, "R3 flow plain", 1);
        run_instr(2'b01, 2'b01, 4'b1000, 1'b1, "R3 flow cof", 1);
        run_instr(2'b01, 2'b01, 4'b0100, 1'b1, "R3 flow sr_write", 1);
        run_instr(2'b10, 2'b10, 4'b0000, 1'b1, "R4 all plain", 1);
        run_instr(2'b10, 2'b10, 4'b1000, 1'b1, "R4 all cof", 1);
        run_instr(2'b01, 2'b01, 4'b1010, 1'b0, "R5 bkpt sub not cof", 1);
        run_instr(2'b01, 2'b01, 4'b0011, 1'b1, "R5 bkpt sub cof", 1);
        run_instr(2'b01, 2'b01, 4'b0110, 1'b1, "R5 bkpt sr_write", 1);
        run_instr(2'b00, 2'b10, 4'b0000, 1'b0, "R6 off at start", 1);
        run_instr(2'b10, 2'b00, 4'b0000, 1'b1, "R6 all at start", 1);
        run_instr(2'b01, 2'b00, 4'b1000, 1'b1, "R6 flow at start", 1);

        orphan_done("R10 orphan done");
        run_instr(2'b10, 2'b10, 4'b0000, 1'b1, "R4 before dup", 1);
        orphan_done("R10 second done");

        // R8: hold without ack, then overlap ack with a new raise
        run_instr(2'b10, 2'b10, 4'b0000, 1'b1, "R8 raise", 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(trace_req == 1'b1, "R8 held without ack", trace_req, 1);
        end
        @(negedge clk);
        mode_bits   = 2'b10;
        instr_start = 1'b1;
        @(negedge clk);
        instr_start = 1'b0;
        instr_done  = 1'b1;
        trace_ack   = 1'b1;
        @(negedge clk);
        instr_done  = 1'b0;
        trace_ack   = 1'b0;
        check(trace_req == 1'b1, "R8 raise wins over ack", trace_req, 1);
        check(trace_vector == 8'd9, "R9 vector held", trace_vector, 9);
        ack_and_check();
        check(trace_vector == 8'd0, "R9 vector idle", trace_vector, 0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule